// File: doc/BRIEF.md
# Two-by-Two Lookup-Table Fabric with Serial Configuration

This block is a very small programmable logic fabric. Four logic cells sit in a two-by-two grid and five switch boxes connect them. Each cell has a 2-input lookup table, a D flip-flop that captures the table output, and a select bit. The select bit decides whether the cell drives its raw table output or the registered copy. The switch boxes connect three user input pins, the four cell outputs and one user output pin. Each switch-box bit closes exactly one fixed connection from a source to a destination.

All configuration state is written through one serial port. The port has its own clock, a data bit and an enable. The port accepts a fixed-length stream that covers every cell and every switch box, including unused ones. When the last bit arrives, a done flag rises. That flag passes through a synchronizer into the user clock domain. The user flip-flops stay cleared until the synchronized flag is high. To change the configuration, assert reset and stream again.

Routes only run from a cell with a lower index to a cell with a higher index. Because of this, no configuration can build a combinational loop.

Top module: `lut_fabric_2x2`

## Requirements
- R1: A configuration stream is 50 bits long. `cfg_done` stays low until the 50th bit accepted with `cfg_en` high, and is high from the next `cfg_clk` edge onward.
- R2: Stream position p (counting from 0) is the p-th accepted bit. Positions 0..19 hold cells 0..3 at 5 bits each. Within a cell, offsets 0..3 are the table entries for index 0..3 and offset 4 is the select bit. Positions 20..49 hold switch boxes 0..4 at 6 bits each, bits 0..5 in order.
- R3: A `cfg_din` value offered while `cfg_en` is low is not stored. A value offered after `cfg_done` is high is also not stored. Neither changes the function the fabric implements.
- R4: A cell's table output is the entry indexed by {in1, in0}, so in1 is the index MSB.
- R5: With select 0, the cell output follows its table combinationally. With select 1, the cell output is the table value captured at the last rising `clk` edge.
- R6: Until `cfg_done` has passed a two-stage synchronizer on `clk`, every cell flip-flop is held at 0.
- R7: Switch-box map, written as bit: source->destination. Sources are A, B, C for the pins, Ck for cell k output, Ck.iN for cell input N, and OUT for the output pin.
  - SB0: 0 A->C0.i0, 1 B->C0.i1, 2 A->C1.i0, 3 B->C1.i1, 4 C0->C1.i0, 5 C0->C1.i1.
  - SB1: 0 A->C2.i0, 1 B->C2.i1, 2 C0->C2.i0, 3 C0->C2.i1, 4 C1->C3.i0, 5 C1->C3.i1.
  - SB2: 0 C->C2.i0, 1 C->C2.i1, 2 C->C3.i0, 3 C->C3.i1, 4 C->C0.i1, 5 C->C1.i1.
  - SB3: 0 C2->C3.i0, 1 C2->C3.i1, 2 C0->C3.i0, 3 C1->C2.i0, 4 C0->C3.i1, 5 C1->C2.i1.
  - SB4: 0 C0->OUT, 1 C1->OUT, 2 C2->OUT, 3 C3->OUT, 4 A->OUT, 5 C->OUT.
- R8: A destination with no closed connection reads 0. A destination with several closed connections reads the OR of their sources.
- R9: Reset (`rst_n` low) clears all configuration bits, the bit counter, `cfg_done` and the cell flip-flops, so `pin_out` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | User clock for the cell flip-flops |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| cfg_clk | input | 1 | Configuration clock |
| cfg_en | input | 1 | Accept `cfg_din` on this `cfg_clk` edge |
| cfg_din | input | 1 | Serial configuration data |
| pin_a | input | 1 | User input A |
| pin_b | input | 1 | User input B |
| pin_c | input | 1 | User input C |
| pin_out | output | 1 | User output pin |
| cfg_done | output | 1 | All 50 configuration bits loaded |

## Verification
The hardest condition to reach is a fabric whose routing and tables are already complete while the flip-flops are still cleared. This lasts from the 49th bit until the synchronized done flag arrives. The bench reaches it by stopping the stream one bit short. It holds the inputs at a pattern that would make the registered cell's output 1, and confirms that `pin_out` stays 0 across several user clocks. During the same load it inserts idle `cfg_en`-low cycles with `cfg_din` at 1, then streams extra bits after done. This shows that neither case shifts or corrupts the stored function.

// File: rtl/fab_pkg.sv
package fab_pkg;
   localparam int LUT_IN     = 2;
   localparam int NUM_CELLS  = 4;
   localparam int NUM_SB     = 5;
   localparam int SB_BITS    = 6;
   localparam int NUM_PINS   = 3;
   localparam int CELL_BITS  = (2 ** LUT_IN) + 1;
   localparam int ROUTE_BASE = NUM_CELLS * CELL_BITS;
   localparam int ROUTE_BITS = NUM_SB * SB_BITS;
   localparam int TOTAL_BITS = ROUTE_BASE + ROUTE_BITS;
   localparam int NUM_SRC    = NUM_PINS + NUM_CELLS;
   localparam int OUT_SINK   = NUM_CELLS * LUT_IN;

   typedef struct packed {
      logic [2:0] src;   // 0..2 pins A,B,C ; 3+k cell k output
      logic [3:0] snk;   // 2*k+p cell k input p ; 8 output pin
   } route_t;

   function automatic route_t mk(input int s, input int d);
      route_t r;
      r.src = 3'(s);
      r.snk = 4'(d);
      return r;
   endfunction

   // fixed connection closed by switch-box bit number idx (box*6 + bit)
   function automatic route_t route_of(input int idx);
      case (idx)
         0:  return mk(0, 0);
         1:  return mk(1, 1);
         2:  return mk(0, 2);
         3:  return mk(1, 3);
         4:  return mk(3, 2);
         5:  return mk(3, 3);
         6:  return mk(0, 4);
         7:  return mk(1, 5);
         8:  return mk(3, 4);
         9:  return mk(3, 5);
         10: return mk(4, 6);
         11: return mk(4, 7);
         12: return mk(2, 4);
         13: return mk(2, 5);
         14: return mk(2, 6);
         15: return mk(2, 7);
         16: return mk(2, 1);
         17: return mk(2, 3);
         18: return mk(5, 6);
         19: return mk(5, 7);
         20: return mk(3, 6);
         21: return mk(4, 4);
         22: return mk(3, 7);
         23: return mk(4, 5);
         24: return mk(3, 8);
         25: return mk(4, 8);
         26: return mk(5, 8);
         27: return mk(6, 8);
         28: return mk(0, 8);
         default: return mk(2, 8);
      endcase
   endfunction
endpackage

// File: rtl/fab_cfg_loader.sv
module fab_cfg_loader #(
   parameter int TOTAL_BITS = 50
) (
   input  logic                  cfg_clk,
   input  logic                  rst_n,
   input  logic                  cfg_en,
   input  logic                  cfg_din,
   output logic [TOTAL_BITS-1:0] cfg_bits,
   output logic                  done
);
   localparam int CNT_W = $clog2(TOTAL_BITS + 1);

   logic [CNT_W-1:0] cnt;

   generate
      if (TOTAL_BITS < 2) begin : g_bad_len
         $error("fab_cfg_loader: TOTAL_BITS must be at least 2");
      end
   endgenerate

   always_ff @(posedge cfg_clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         cfg_bits <= '0;
         done     <= 1'b0;
      end else if (cfg_en && !done) begin
         cfg_bits[cnt] <= cfg_din;
         cnt           <= cnt + 1'b1;
         if (cnt == CNT_W'(TOTAL_BITS - 1)) done <= 1'b1;
      end
   end

   assert_count_range_R1: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      cnt <= CNT_W'(TOTAL_BITS));
   assert_done_at_end_R1: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      $rose(done) |-> cnt == CNT_W'(TOTAL_BITS));
   assert_done_sticky_R1: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      done |=> done);
   assert_frozen_after_done_R3: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      done |=> $stable(cfg_bits));
   assert_idle_no_write_R3: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      !cfg_en |=> ($stable(cfg_bits) && $stable(cnt)));
endmodule

// File: rtl/fab_ready_sync.sv
module fab_ready_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("fab_ready_sync: STAGES must be at least 1");
      end else if (STAGES == 1) begin : g_single
         logic s0;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s0 <= 1'b0;
            else        s0 <= async_in;
         end
         assign sync_out = s0;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], async_in};
         end
         assign sync_out = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/fab_cell_ff.sv
module fab_cell_ff (
   input  logic clk,
   input  logic rst_n,
   input  logic ready,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= 1'b0;
      else if (!ready) q <= 1'b0;
      else             q <= d;
   end

   assert_hold_until_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |=> q == 1'b0);
   assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> q == $past(d));
endmodule

// File: rtl/fab_route.sv
module fab_route
   import fab_pkg::*;
(
   input  logic [TOTAL_BITS-1:0] cfg_bits,
   input  logic [NUM_PINS-1:0]   pins,
   input  logic [NUM_CELLS-1:0]  q,
   output logic [NUM_CELLS-1:0]  lut_d,
   output logic                  pin_out
);
   // value of one destination: OR of every source whose connection bit is closed
   function automatic logic net_val(input logic [TOTAL_BITS-1:0] bits,
                                    input logic [NUM_SRC-1:0]    sv,
                                    input int                    snk);
      logic   acc;
      route_t r;
      acc = 1'b0;
      for (int k = 0; k < ROUTE_BITS; k++) begin
         r = route_of(k);
         if (bits[ROUTE_BASE + k] && (int'(r.snk) == snk)) acc = acc | sv[r.src];
      end
      return acc;
   endfunction

   always_comb begin
      logic [NUM_SRC-1:0] sv;
      logic [LUT_IN-1:0]  idx;
      logic               tbl;
      sv             = '0;
      sv[NUM_PINS-1:0] = pins;
      lut_d          = '0;
      // cells evaluated in index order: routes only feed higher-numbered cells
      for (int c = 0; c < NUM_CELLS; c++) begin
         for (int p = 0; p < LUT_IN; p++) idx[p] = net_val(cfg_bits, sv, c*LUT_IN + p);
         tbl      = cfg_bits[c*CELL_BITS + int'(idx)];
         lut_d[c] = tbl;
         sv[NUM_PINS + c] = cfg_bits[c*CELL_BITS + CELL_BITS - 1] ? q[c] : tbl;
      end
      pin_out = net_val(cfg_bits, sv, OUT_SINK);
   end
endmodule

// File: rtl/lut_fabric_2x2.sv
module lut_fabric_2x2
   import fab_pkg::*;
#(
   parameter int LUT_INPUTS  = 2,
   parameter int CELLS       = 4,
   parameter int SWITCHES    = 5,
   parameter int SWITCH_BITS = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_clk,
   input  logic cfg_en,
   input  logic cfg_din,
   input  logic pin_a,
   input  logic pin_b,
   input  logic pin_c,
   output logic pin_out,
   output logic cfg_done
);
   localparam int STREAM_LEN = CELLS * ((2 ** LUT_INPUTS) + 1) + SWITCHES * SWITCH_BITS;

   generate
      if (LUT_INPUTS != LUT_IN || CELLS != NUM_CELLS ||
          SWITCHES != NUM_SB || SWITCH_BITS != SB_BITS) begin : g_bad_shape
         $error("lut_fabric_2x2: shape parameters must match the fixed routing map");
      end
      if (STREAM_LEN != TOTAL_BITS) begin : g_bad_len
         $error("lut_fabric_2x2: stream length mismatch");
      end
   endgenerate

   logic [STREAM_LEN-1:0] cfg_bits;
   logic                  ready;
   logic [CELLS-1:0]      lut_d;
   logic [CELLS-1:0]      q;

   fab_cfg_loader #(.TOTAL_BITS(STREAM_LEN)) u_loader (
      .cfg_clk (cfg_clk),
      .rst_n   (rst_n),
      .cfg_en  (cfg_en),
      .cfg_din (cfg_din),
      .cfg_bits(cfg_bits),
      .done    (cfg_done)
   );

   fab_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in(cfg_done),
      .sync_out(ready)
   );

   generate
      for (genvar c = 0; c < CELLS; c++) begin : g_cell
         fab_cell_ff u_ff (
            .clk  (clk),
            .rst_n(rst_n),
            .ready(ready),
            .d    (lut_d[c]),
            .q    (q[c])
         );
      end
   endgenerate

   fab_route u_route (
      .cfg_bits(cfg_bits),
      .pins    ({pin_c, pin_b, pin_a}),
      .q       (q),
      .lut_d   (lut_d),
      .pin_out (pin_out)
   );

   assert_ready_needs_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> cfg_done);
   assert_idle_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_bits == '0) |-> pin_out == 1'b0);
endmodule

// File: tb/tb_lut_fabric_2x2.sv
module tb_lut_fabric_2x2;
   localparam int CLK_PERIOD = 10;
   localparam int CFG_PERIOD = 16;
   localparam int N = 50;

   logic clk = 0, cfg_clk = 0;
   logic rst_n = 0, cfg_en = 0, cfg_din = 0;
   logic pin_a = 0, pin_b = 0, pin_c = 0;
   logic pin_out, cfg_done;
   int   n_run = 0, n_fail = 0, cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always #(CFG_PERIOD/2) cfg_clk = ~cfg_clk;

   lut_fabric_2x2 dut (
      .clk(clk), .rst_n(rst_n), .cfg_clk(cfg_clk), .cfg_en(cfg_en), .cfg_din(cfg_din),
      .pin_a(pin_a), .pin_b(pin_b), .pin_c(pin_c), .pin_out(pin_out), .cfg_done(cfg_done)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [N-1:0] put_cell(input logic [N-1:0] s, input int c,
                                             input logic [3:0] lut, input logic sel);
      for (int k = 0; k < 4; k++) s[c*5 + k] = lut[k];
      s[c*5 + 4] = sel;
      return s;
   endfunction

   function automatic logic [N-1:0] put_sb(input logic [N-1:0] s, input int sb, input int b);
      s[20 + sb*6 + b] = 1'b1;
      return s;
   endfunction

   task automatic send_bits(input logic [N-1:0] s, input int from, input int upto);
      for (int i = from; i < upto; i++) begin
         @(negedge cfg_clk); cfg_en = 1; cfg_din = s[i];
      end
      @(negedge cfg_clk); cfg_en = 0; cfg_din = 0;
   endtask

   task automatic do_reset();
      rst_n = 0; cfg_en = 0; cfg_din = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic set_pins(input logic [2:0] v);
      pin_a = v[0]; pin_b = v[1]; pin_c = v[2];
   endtask

   // R9: reset state
   task automatic t_reset();
      rst_n = 0;
      for (int v = 0; v < 8; v += 3) begin
         set_pins(3'(v)); #1;
         check("R9 out in reset", pin_out, 1'b0);
      end
      check("R9 done in reset", cfg_done, 1'b0);
      do_reset();
      set_pins(3'b111); #1;
      check("R8 unconfigured out", pin_out, 1'b0);
      check("R1 done after reset", cfg_done, 1'b0);
   endtask

   // AND of A,B in cell 0 (direct) -> XOR with C in cell 2 (registered) -> out
   function automatic logic [N-1:0] stream_gate();
      logic [N-1:0] s = '0;
      s = put_cell(s, 0, 4'b1000, 1'b0);
      s = put_cell(s, 2, 4'b0110, 1'b1);
      s = put_sb(s, 0, 0);
      s = put_sb(s, 0, 1);
      s = put_sb(s, 1, 2);
      s = put_sb(s, 2, 1);
      s = put_sb(s, 4, 2);
      return s;
   endfunction

   // R1, R3, R6: partial load, idle cycles, done timing, extra bits
   task automatic t_load_gate();
      logic [N-1:0] s = stream_gate();
      do_reset();
      send_bits(s, 0, 20);
      repeat (5) begin @(negedge cfg_clk); cfg_en = 0; cfg_din = 1; end
      cfg_din = 0;
      send_bits(s, 20, N-1);
      check("R1 done low at 49 bits", cfg_done, 1'b0);
      set_pins(3'b011);
      repeat (4) @(negedge clk);
      check("R6 flops held before done", pin_out, 1'b0);
      send_bits(s, N-1, N);
      check("R1 done high at 50 bits", cfg_done, 1'b1);
      send_bits('1, 0, 6);
      check("R1 done stays high", cfg_done, 1'b1);
      repeat (4) @(negedge clk);
      check("R6 runs after done", pin_out, 1'b1);
   endtask

   // R2, R4, R5, R7: registered output cycle by cycle
   task automatic t_registered();
      logic prev = 1'b1;
      for (int v = 0; v < 8; v++) begin
         logic e;
         @(negedge clk);
         set_pins(3'(v)); #1;
         check("R5 no change before edge", pin_out, prev);
         e = (pin_a & pin_b) ^ pin_c;
         @(posedge clk); #1;
         check("R4 R7 registered gate", pin_out, e);
         check("R3 extra bits ignored", pin_out, e);
         prev = e;
      end
   endtask

   // R2, R5, R8: combinational NOT A in cell 1, OR with C at the output
   task automatic t_comb_or();
      logic [N-1:0] s = '0;
      s = put_cell(s, 1, 4'b0101, 1'b0);
      s = put_sb(s, 0, 2);
      s = put_sb(s, 4, 1);
      s = put_sb(s, 4, 5);
      do_reset();
      send_bits(s, 0, N);
      repeat (4) @(negedge clk);
      for (int v = 7; v >= 0; v--) begin
         set_pins(3'(v)); #1;
         check("R5 R8 direct path OR", pin_out, ~pin_a | pin_c);
      end
   endtask

   // R8: unrouted cell inputs read 0; unrouted constant cell does not reach out
   task automatic t_open_nets();
      logic [N-1:0] s = '0;
      s = put_cell(s, 0, 4'b0110, 1'b0);
      s = put_cell(s, 3, 4'b1111, 1'b0);
      s = put_sb(s, 4, 0);
      do_reset();
      send_bits(s, 0, N);
      repeat (4) @(negedge clk);
      for (int v = 0; v < 8; v++) begin
         set_pins(3'(v)); #1;
         check("R8 open inputs read 0", pin_out, 1'b0);
      end
   endtask

   initial begin
      t_reset();
      t_load_gate();
      t_registered();
      t_comb_or();
      t_open_nets();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
         end
      end
   end
endmodule